// File: doc/BRIEF.md
# Threshold-Crossing Period Meter

This block measures the period of a sampled waveform. It watches a stream of signed samples and finds each point where the signal moves upward past a programmable threshold. It reports the time between such points as a number of samples. The result is a fixed-point value with 16 fractional bits.

Each crossing instant can be refined below one sample. The refinement uses linear interpolation between the two samples on either side of the threshold. A bit-serial divider produces an 8-bit fraction for this. When interpolation is switched off, the divider is skipped and the crossing falls on a whole sample.

To gain precision beyond what one crossing gives, the block can time a power-of-two number of cycles and report their average. If too many samples pass before the required crossings arrive, the block raises a timeout pulse and starts over.

Top module: `xing_period_meter`

## Requirements
- R1: A rising crossing is recognised on an accepted sample when the previous accepted sample is at or below the threshold and the current one is strictly above it. The comparison is two's-complement signed. The first sample after reset has no predecessor and never forms a crossing.
- R2: With `interp_en` high, the crossing time in samples is the index of the earlier sample plus f/256. Here f = floor(256·(thresh − prev)/(cur − prev)) is an unsigned 8-bit value.
- R3: With `interp_en` low, f is 0, so the crossing sits on the earlier sample's index, and the divider stays idle.
- R4: The first crossing after reset, after a result or after a timeout opens a window and latches `avg_log2` = k. The 2^k-th further crossing closes the window and produces one result. A closing crossing never opens the next window.
- R5: `period_q` = floor((T_close − T_open)·2^16 / 2^k). T is measured in samples and the 8-bit fraction fills bits 15:8 before the shift.
- R6: Cycles with `smp_valid` low are ignored. They do not advance the sample index, are not tested for a crossing, and their data has no effect.
- R7: The divider retires one quotient bit per clock. It is busy for at most 8 consecutive cycles per crossing.
- R8: A crossing detected while the divider is busy is held in a one-entry slot. It is processed afterwards, in order, and none is lost as long as at most one crossing waits.
- R9: A valid sample arriving after 2^CNT_W − 1 valid samples have been counted in an open window fires a one-cycle `timeout`. The window is discarded without a result.
- R10: `period_valid` and `timeout` are single-cycle pulses. They are never high together, and both are low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed sample |
| thresh | input | SAMPLE_W | Signed threshold |
| interp_en | input | 1 | Enable sub-sample interpolation |
| avg_log2 | input | K_W | log2 of the number of periods averaged |
| period_valid | output | 1 | Result strobe |
| period_q | output | CNT_W+16 | Period in samples, 16 fractional bits |
| timeout | output | 1 | Window abandoned after counter overflow |

## Verification
The checker watches the following on every cycle:
- every crossing event follows an accepted sample;
- the divider never stays busy longer than its bit count;
- the hold slot is never overrun;
- a result only appears right after a timestamp;
- a timeout only follows a valid sample;
- the two output strobes are single and exclusive.

The arithmetic itself can only be shown by the bench's scenarios, which compare results against periods computed from the same sample stream. This covers:
- the interpolated fractions;
- the averaging shift for every k;
- gaps in the sample stream;
- back-to-back crossings that force the hold slot;
- the overflow timeout and the window that follows it.

// File: rtl/xpm_pkg.sv
// Shared constants and types for the threshold-crossing period meter.
// Assumes nothing beyond a fixed 16-bit fractional output format.
package xpm_pkg;
    // Fractional bits of the reported period.
    localparam int OUT_FRAC = 16;

    // Measurement window state.
    typedef enum logic [0:0] {
        WIN_IDLE = 1'b0,
        WIN_RUN  = 1'b1
    } win_state_t;
endpackage

// File: rtl/xpm_detect.sv
// Rising-crossing detector. Keeps the previous accepted sample and a wrapping
// sample index, and emits one registered event per rising crossing with the
// interpolation numerator/denominator and the earlier sample's index.
// Assumes thresh is stable while a crossing is being evaluated.
module xpm_detect #(
    parameter int SAMPLE_W = 16,
    parameter int CNT_W    = 24,
    localparam int DIFF_W  = SAMPLE_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [SAMPLE_W-1:0] thresh,
    output logic                evt_valid,
    output logic [DIFF_W-1:0]   evt_num,
    output logic [DIFF_W-1:0]   evt_den,
    output logic [CNT_W-1:0]    evt_idx
);
    logic [SAMPLE_W-1:0] prev_q;
    logic                have_prev;
    logic [CNT_W-1:0]    sidx;
    logic                rising;
    logic [DIFF_W-1:0]   num_c;
    logic [DIFF_W-1:0]   den_c;

    // Crossing test and sign-extended differences for the divider.
    always_comb begin
        rising = smp_valid && have_prev
                 && ($signed(prev_q) <= $signed(thresh))
                 && ($signed(smp_data) > $signed(thresh));
        num_c  = {thresh[SAMPLE_W-1], thresh} - {prev_q[SAMPLE_W-1], prev_q};
        den_c  = {smp_data[SAMPLE_W-1], smp_data} - {prev_q[SAMPLE_W-1], prev_q};
    end

    // Sample history and index of the incoming sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            have_prev <= 1'b0;
            sidx      <= '0;
        end else if (smp_valid) begin
            prev_q    <= smp_data;
            have_prev <= 1'b1;
            sidx      <= sidx + 1'b1;
        end
    end

    // Registered crossing event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_num   <= '0;
            evt_den   <= '0;
            evt_idx   <= '0;
        end else begin
            evt_valid <= rising;
            if (rising) begin
                evt_num <= num_c;
                evt_den <= den_c;
                evt_idx <= sidx - 1'b1;
            end
        end
    end
endmodule

// File: rtl/xpm_divider.sv
// Bit-serial restoring divider for a proper fraction num/den (num < den).
// Produces floor(num * 2^QUOT_W / den), one quotient bit per clock, and
// pulses done for one cycle after the last bit. A start while busy is ignored.
module xpm_divider #(
    parameter int NUM_W   = 17,
    parameter int QUOT_W  = 8,
    localparam int STEP_W = $clog2(QUOT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NUM_W-1:0]  num,
    input  logic [NUM_W-1:0]  den,
    output logic              busy,
    output logic              done,
    output logic [QUOT_W-1:0] quot
);
    logic [NUM_W-1:0]  rem;
    logic [NUM_W-1:0]  den_q;
    logic [STEP_W-1:0] steps;
    logic [NUM_W:0]    trial;
    logic [NUM_W:0]    diff;
    logic              fits;

    // One restoring step: doubled remainder against the divisor.
    always_comb begin
        trial = {rem, 1'b0};
        fits  = trial >= {1'b0, den_q};
        diff  = trial - {1'b0, den_q};
    end

    // Iteration control, remainder and quotient shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= '0;
            den_q <= '0;
            steps <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
            quot  <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                rem   <= num;
                den_q <= den;
                steps <= STEP_W'(QUOT_W);
                busy  <= 1'b1;
                quot  <= '0;
            end else if (busy) begin
                rem   <= fits ? diff[NUM_W-1:0] : trial[NUM_W-1:0];
                quot  <= {quot[QUOT_W-2:0], fits};
                steps <= steps - 1'b1;
                if (steps == STEP_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/xpm_interp.sv
// Crossing timestamper. Holds one pending crossing in a slot, launches it into
// the divider (or straight through with a zero fraction when interpolation is
// off) once the engine is free, and emits the timestamp {index, fraction}.
// Assumes no more than one crossing waits while the divider is working.
module xpm_interp #(
    parameter int SAMPLE_W  = 16,
    parameter int CNT_W     = 24,
    parameter int FRAC_BITS = 8,
    localparam int DIFF_W   = SAMPLE_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 interp_en,
    input  logic                 evt_valid,
    input  logic [DIFF_W-1:0]    evt_num,
    input  logic [DIFF_W-1:0]    evt_den,
    input  logic [CNT_W-1:0]     evt_idx,
    output logic                 ts_valid,
    output logic [CNT_W-1:0]     ts_idx,
    output logic [FRAC_BITS-1:0] ts_frac,
    output logic                 div_busy,
    output logic                 slot_overrun
);
    logic                 slot_v;
    logic [DIFF_W-1:0]    slot_num;
    logic [DIFF_W-1:0]    slot_den;
    logic [CNT_W-1:0]     slot_idx;
    logic [CNT_W-1:0]     run_idx;
    logic                 div_done;
    logic [FRAC_BITS-1:0] div_q;
    logic                 launch;
    logic                 launch_div;
    logic                 launch_byp;

    // Launch decision and overrun detection.
    always_comb begin
        launch       = slot_v && !div_busy && !div_done;
        launch_div   = launch && interp_en;
        launch_byp   = launch && !interp_en;
        slot_overrun = evt_valid && slot_v && !launch;
    end

    // One-entry hold slot for a crossing waiting on the divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v   <= 1'b0;
            slot_num <= '0;
            slot_den <= '0;
            slot_idx <= '0;
        end else if (evt_valid && (!slot_v || launch)) begin
            slot_v   <= 1'b1;
            slot_num <= evt_num;
            slot_den <= evt_den;
            slot_idx <= evt_idx;
        end else if (launch) begin
            slot_v <= 1'b0;
        end
    end

    // Index of the crossing currently inside the divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_idx <= '0;
        end else if (launch_div) begin
            run_idx <= slot_idx;
        end
    end

    // Timestamp output from either the bypass or the divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_valid <= 1'b0;
            ts_idx   <= '0;
            ts_frac  <= '0;
        end else begin
            ts_valid <= launch_byp || div_done;
            if (launch_byp) begin
                ts_idx  <= slot_idx;
                ts_frac <= '0;
            end else if (div_done) begin
                ts_idx  <= run_idx;
                ts_frac <= div_q;
            end
        end
    end

    xpm_divider #(
        .NUM_W  (DIFF_W),
        .QUOT_W (FRAC_BITS)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (launch_div),
        .num   (slot_num),
        .den   (slot_den),
        .busy  (div_busy),
        .done  (div_done),
        .quot  (div_q)
    );
endmodule

// File: rtl/xpm_window.sv
// Averaging window. Opens on a timestamp, counts 2^k further timestamps,
// then reports (elapsed time * 2^16) >> k. A span counter of valid samples
// abandons the window with a timeout when it overflows.
// Assumes one window never spans more than 2^CNT_W samples.
module xpm_window
    import xpm_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int FRAC_BITS = 8,
    parameter int K_W       = 3,
    localparam int TS_W     = CNT_W + FRAC_BITS,
    localparam int PER_W    = CNT_W + OUT_FRAC,
    localparam int PAD      = OUT_FRAC - FRAC_BITS,
    localparam int HIT_W    = (1 << K_W) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic [K_W-1:0]       avg_log2,
    input  logic                 ts_valid,
    input  logic [CNT_W-1:0]     ts_idx,
    input  logic [FRAC_BITS-1:0] ts_frac,
    output logic                 period_valid,
    output logic [PER_W-1:0]     period_q,
    output logic                 timeout
);
    win_state_t       state;
    logic [TS_W-1:0]  start_ts;
    logic [TS_W-1:0]  ts_now;
    logic [TS_W-1:0]  elapsed;
    logic [PER_W-1:0] scaled;
    logic [CNT_W-1:0] span;
    logic [HIT_W-1:0] hits;
    logic [HIT_W-1:0] hits_nx;
    logic [HIT_W-1:0] goal;
    logic [K_W-1:0]   k_q;
    logic             span_full;

    // Elapsed time, scaled average and window-closing target.
    always_comb begin
        ts_now    = {ts_idx, ts_frac};
        elapsed   = ts_now - start_ts;
        scaled    = (PER_W'(elapsed) << PAD) >> k_q;
        goal      = HIT_W'(1) << k_q;
        hits_nx   = hits + 1'b1;
        span_full = &span;
    end

    // Window sequencing, timeout and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= WIN_IDLE;
            start_ts     <= '0;
            span         <= '0;
            hits         <= '0;
            k_q          <= '0;
            period_valid <= 1'b0;
            period_q     <= '0;
            timeout      <= 1'b0;
        end else begin
            period_valid <= 1'b0;
            timeout      <= 1'b0;
            case (state)
                WIN_IDLE: begin
                    if (ts_valid) begin
                        state    <= WIN_RUN;
                        start_ts <= ts_now;
                        span     <= '0;
                        hits     <= '0;
                        k_q      <= avg_log2;
                    end
                end
                WIN_RUN: begin
                    if (smp_valid && span_full) begin
                        timeout <= 1'b1;
                        state   <= WIN_IDLE;
                    end else begin
                        if (smp_valid) begin
                            span <= span + 1'b1;
                        end
                        if (ts_valid) begin
                            hits <= hits_nx;
                            if (hits_nx == goal) begin
                                period_valid <= 1'b1;
                                period_q     <= scaled;
                                state        <= WIN_IDLE;
                            end
                        end
                    end
                end
                default: state <= WIN_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xing_period_meter.sv
// Top of the threshold-crossing period meter: detector, interpolating
// timestamper and averaging window in a chain. Period is reported in samples
// with 16 fractional bits. Assumes FRAC_BITS < 16 and crossings spaced so that
// at most one waits for the divider.
module xing_period_meter
    import xpm_pkg::*;
#(
    parameter int SAMPLE_W  = 16,
    parameter int CNT_W     = 24,
    parameter int FRAC_BITS = 8,
    parameter int K_W       = 3,
    localparam int DIFF_W   = SAMPLE_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        smp_valid,
    input  logic [SAMPLE_W-1:0]         smp_data,
    input  logic [SAMPLE_W-1:0]         thresh,
    input  logic                        interp_en,
    input  logic [K_W-1:0]              avg_log2,
    output logic                        period_valid,
    output logic [CNT_W+OUT_FRAC-1:0]   period_q,
    output logic                        timeout
);
    logic                 evt_valid;
    logic [DIFF_W-1:0]    evt_num;
    logic [DIFF_W-1:0]    evt_den;
    logic [CNT_W-1:0]     evt_idx;
    logic                 ts_valid;
    logic [CNT_W-1:0]     ts_idx;
    logic [FRAC_BITS-1:0] ts_frac;
    logic                 div_busy;
    logic                 slot_overrun;

    xpm_detect #(
        .SAMPLE_W (SAMPLE_W),
        .CNT_W    (CNT_W)
    ) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .thresh    (thresh),
        .evt_valid (evt_valid),
        .evt_num   (evt_num),
        .evt_den   (evt_den),
        .evt_idx   (evt_idx)
    );

    xpm_interp #(
        .SAMPLE_W  (SAMPLE_W),
        .CNT_W     (CNT_W),
        .FRAC_BITS (FRAC_BITS)
    ) u_interp (
        .clk          (clk),
        .rst_n        (rst_n),
        .interp_en    (interp_en),
        .evt_valid    (evt_valid),
        .evt_num      (evt_num),
        .evt_den      (evt_den),
        .evt_idx      (evt_idx),
        .ts_valid     (ts_valid),
        .ts_idx       (ts_idx),
        .ts_frac      (ts_frac),
        .div_busy     (div_busy),
        .slot_overrun (slot_overrun)
    );

    xpm_window #(
        .CNT_W     (CNT_W),
        .FRAC_BITS (FRAC_BITS),
        .K_W       (K_W)
    ) u_window (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_valid    (smp_valid),
        .avg_log2     (avg_log2),
        .ts_valid     (ts_valid),
        .ts_idx       (ts_idx),
        .ts_frac      (ts_frac),
        .period_valid (period_valid),
        .period_q     (period_q),
        .timeout      (timeout)
    );
endmodule

// File: rtl/xpm_checker.sv
// Cycle-level properties of the period meter, bound to its top module.
// Watches the stage hand-off strobes and the divider busy run length.
module xpm_checker #(
    parameter int FRAC_BITS = 8,
    localparam int RUN_W    = $clog2(FRAC_BITS + 2) + 1
) (
    input logic clk,
    input logic rst_n,
    input logic smp_valid,
    input logic evt_valid,
    input logic div_busy,
    input logic slot_overrun,
    input logic ts_valid,
    input logic period_valid,
    input logic timeout
);
    logic [RUN_W-1:0] busy_run;

    // Length of the current divider busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else begin
            busy_run <= div_busy ? busy_run + 1'b1 : '0;
        end
    end

    AST_EVT_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) evt_valid |-> $past(smp_valid)); // R1
    AST_DIV_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) busy_run <= RUN_W'(FRAC_BITS)); // R7
    AST_SLOT_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n) !slot_overrun); // R8
    AST_RESULT_AFTER_TS: assert property (@(posedge clk) disable iff (!rst_n) period_valid |-> $past(ts_valid)); // R4
    AST_TIMEOUT_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) timeout |-> $past(smp_valid)); // R9
    AST_RESULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) period_valid |=> !period_valid); // R10
    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(period_valid && timeout)); // R10
endmodule

bind xing_period_meter xpm_checker #(
    .FRAC_BITS (FRAC_BITS)
) u_xpm_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_valid    (smp_valid),
    .evt_valid    (evt_valid),
    .div_busy     (div_busy),
    .slot_overrun (slot_overrun),
    .ts_valid     (ts_valid),
    .period_valid (period_valid),
    .timeout      (timeout)
);

// File: tb/xing_period_meter_test.sv
// Sweeps threshold, slope, interpolation mode and averaging depth on a small
// configuration; expected periods are computed from the driven samples.
module xing_period_meter_test;
    localparam int SW    = 12;
    localparam int CW    = 12;
    localparam int FB    = 8;
    localparam int KW    = 3;
    localparam int PER_W = CW + 16;
    localparam int M     = 1600;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             smp_valid = 1'b0;
    logic [SW-1:0]    smp_data = '0;
    logic [SW-1:0]    thresh = '0;
    logic             interp_en = 1'b0;
    logic [KW-1:0]    avg_log2 = '0;
    logic             period_valid;
    logic [PER_W-1:0] period_q;
    logic             timeout;

    int     checks = 0;
    int     failures = 0;
    int     n_timeout = 0;
    longint obs_q[$];
    int     vals[$];

    always #2 clk = ~clk;

    xing_period_meter #(
        .SAMPLE_W  (SW),
        .CNT_W     (CW),
        .FRAC_BITS (FB),
        .K_W       (KW)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_valid    (smp_valid),
        .smp_data     (smp_data),
        .thresh       (thresh),
        .interp_en    (interp_en),
        .avg_log2     (avg_log2),
        .period_valid (period_valid),
        .period_q     (period_q),
        .timeout      (timeout)
    );

    // Output monitor, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (period_valid) obs_q.push_back(longint'(period_q));
            if (timeout) n_timeout++;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // R10: outputs quiet while reset is held.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(period_valid == 1'b0 && timeout == 1'b0, "R10 reset",
              longint'({period_valid, timeout}), 0);
        obs_q.delete();
        vals.delete();
        n_timeout = 0;
        rst_n = 1'b1;
    endtask

    // R6: invalid cycles carry a value that would cross if it were counted.
    task automatic push(input bit v, input int val);
        @(negedge clk);
        smp_valid = v;
        smp_data  = v ? val[SW-1:0] : 12'h7FF;
        if (v) vals.push_back(val);
    endtask

    // Expected results from the accepted samples (R1 crossing rule, R2/R3 fraction, R4/R5 windows).
    task automatic model(input int th, input bit ie, input int k, output longint exp_q[$]);
        longint ts_list[$];
        exp_q.delete();
        for (int n = 1; n < vals.size(); n++) begin
            if (vals[n-1] <= th && vals[n] > th) begin
                longint fr;
                fr = ie ? (longint'(th - vals[n-1]) * 256) / longint'(vals[n] - vals[n-1]) : 0;
                ts_list.push_back(longint'(n - 1) * 256 + fr);
            end
        end
        for (int i = 0; i + (1 << k) < ts_list.size(); i += (1 << k) + 1) begin
            exp_q.push_back(((ts_list[i + (1 << k)] - ts_list[i]) * 256) >> k);
        end
    endtask

    // mode 0: sawtooth with gaps; mode 1: crossing bursts two samples apart.
    task automatic run_cfg(input int th, input bit ie, input int k, input int step, input int mode);
        longint exp_q[$];
        int     nsamp;
        int     c;
        string  vtag;
        do_reset();
        thresh    = th[SW-1:0];
        interp_en = ie;
        avg_log2  = k[KW-1:0];
        if (mode == 0) begin
            nsamp = (2 * ((1 << k) + 1) + 2) * (M / step + 2);
            c = 0;
            for (int n = 0; n < nsamp; n++) begin
                if (c % 7 == 6) begin
                    push(1'b0, 0);
                    c++;
                end
                push(1'b1, -800 + ((n * step) % M));
                c++;
            end
            vtag = ie ? "R2 R5 R6 R7" : "R3 R5 R6";
        end else begin
            for (int rep = 0; rep < 8; rep++) begin
                push(1'b1, -100);
                push(1'b1, 100);
                push(1'b1, -100);
                push(1'b1, 300);
                for (int j = 0; j < 36; j++) push(1'b1, -100);
            end
            vtag = "R8 R2 R5";
        end
        for (int j = 0; j < 30; j++) push(1'b0, 0);
        model(th, ie, k, exp_q);
        check(obs_q.size() == exp_q.size() && exp_q.size() > 0, "R1 R4 count",
              obs_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < obs_q.size(); i++) begin
            check(obs_q[i] == exp_q[i], vtag, obs_q[i], exp_q[i]);
        end
    endtask

    // R9: window abandoned on span overflow, then a fresh window measures correctly.
    task automatic run_timeout();
        do_reset();
        thresh    = '0;
        interp_en = 1'b0;
        avg_log2  = '0;
        push(1'b1, -100);
        push(1'b1, 100);
        for (int j = 0; j < 4300; j++) push(1'b1, -100);
        check(n_timeout == 1, "R9 timeout pulse", n_timeout, 1);
        check(obs_q.size() == 0, "R9 no result", obs_q.size(), 0);
        push(1'b1, 100);
        push(1'b1, -100);
        push(1'b1, -100);
        push(1'b1, -100);
        push(1'b1, 100);
        for (int j = 0; j < 20; j++) push(1'b0, 0);
        check(obs_q.size() == 1, "R9 R4 restart count", obs_q.size(), 1);
        if (obs_q.size() == 1) check(obs_q[0] == 4 * 65536, "R9 R5 restart value", obs_q[0], 4 * 65536);
        check(n_timeout == 1, "R9 single timeout", n_timeout, 1);
    endtask

    initial begin
        int ths[3];
        int steps[3];
        ths[0] = 0;   ths[1] = 313; ths[2] = -517;
        steps[0] = 37; steps[1] = 53; steps[2] = 29;
        for (int k = 0; k <= 4; k++) begin
            for (int ie = 0; ie < 2; ie++) begin
                for (int t = 0; t < 3; t++) begin
                    run_cfg(ths[t], ie[0], k, steps[t], 0);
                end
            end
        end
        run_cfg(211, 1'b1, 7, 61, 0);
        run_cfg(0, 1'b1, 0, 1, 1);
        run_cfg(0, 1'b1, 1, 1, 1);
        run_cfg(0, 1'b0, 0, 1, 1);
        run_timeout();
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 190000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        summary();
        $finish;
    end
endmodule